// File: doc/BRIEF.md
# SPI master with timed chip-select

This block shifts one word of 4 to 32 bits out of a serial peripheral link and captures the word the peripheral returns. It drives the serial clock, the outgoing data line and one chip-select line, and it samples the incoming data line. The host presents the word, its length, a clock divide ratio, a chip-select delay code, a polarity bit and a mode bit, then pulses `start`. Only SPI mode 0 is supported: the serial clock idles low, outgoing data changes on falling edges, incoming data is sampled on rising edges, and the most significant bit goes first.

In automatic mode the hardware times the chip-select line. It asserts the line, waits a lead interval, shifts the word, waits a trail interval of the same length, then releases the line. Each interval lasts an odd number of half serial-clock periods. A delay code of zero therefore still gives half a period. In manual mode the block does not time chip-select: the line tracks a software force bit, so software can keep a peripheral selected across several words.

Top module: `spi_cs_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `sclk` is 0, `busy` is 0, `done` is 0 and `cs` is at the inactive level for the current `cs_pol`. This means `cs` is 1 when `cs_pol`=0 and 0 when `cs_pol`=1.
- R2: In automatic mode (`cs_manual`=0), `cs` goes active in the first cycle that `busy` is 1. The first rising edge of `sclk` follows (2*`cs_lead`+1)*`div_ratio`/2 clock cycles after that. With `cs_lead`=0 and `div_ratio`=8 this is 4 cycles, which is half a serial period.
- R3: In automatic mode, `cs` goes inactive exactly (2*`cs_lead`+1)*`div_ratio`/2 clock cycles after the last falling edge of `sclk`. `cs` stays active without a break from assertion to that point.
- R4: During a word, `sclk` gives exactly `word_len` rising edges, spaced `div_ratio` clock cycles apart. `div_ratio` is an even number from 2 to 256. `sclk` is 0 whenever the block is idle.
- R5: At the k-th rising edge of `sclk` (k = 1..`word_len`), `mosi` carries bit `word_len`-k of `tx_word`. Only the low `word_len` bits are sent, and `mosi` changes only after falling edges.
- R6: `miso` is sampled at each rising edge of `sclk`. When `done` is high, `rx_word` holds the sampled bits in its low `word_len` bits, with the first bit sampled as the most significant of them. All bits above them are 0.
- R7: In manual mode (`cs_manual`=1), one cycle after any change, `cs` equals `cs_pol` when `cs_force`=1 and the inverse of `cs_pol` when `cs_force`=0. This holds both when idle and during a word. The first rising edge of `sclk` follows `div_ratio`/2 cycles after `busy` rises.
- R8: `cs_pol`=1 makes chip-select active-high and `cs_pol`=0 makes it active-low. The level used during a word is the one present when the word was accepted.
- R9: A `start` pulse while `busy` is 1 has no effect. The word in flight completes unchanged, and `busy` is 0 in the cycle after `done`.
- R10: `done` is high for exactly one cycle per word. In automatic mode it is high in the first cycle that `cs` is inactive. In manual mode it is high in the cycle `sclk` falls for the last time.
- R11: `word_len` is accepted from 4 to 32. The ends of that range, 4 and 32, behave as R4 to R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference for the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to send a word, taken only while idle |
| tx_word | input | 32 | Word to send, right-aligned |
| word_len | input | 6 | Number of bits in the word, 4 to 32 |
| div_ratio | input | 9 | Serial clock period in system clock cycles, even, 2 to 256 |
| cs_lead | input | 2 | Chip-select delay code, 0 to 3 |
| cs_pol | input | 1 | 1: chip-select active high, 0: active low |
| cs_manual | input | 1 | 1: chip-select follows `cs_force`, 0: hardware-timed |
| cs_force | input | 1 | Requested chip-select state in manual mode |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs | output | 1 | Chip-select line |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_word | output | 32 | Received word, valid with `done` |

## Verification
Two situations are hard to reach from the ports. The first is a `start` pulse that arrives in the middle of a word. To produce it, the bench slave-side monitor raises `start` right after it sees the second falling `sclk` edge. It then checks that both the outgoing bits and the received bits belong to the first word only, and that the block is idle after `done`. The second is exact lead and trail counting at the extremes. The bench runs the shortest divide ratio with the largest delay code, and the longest ratio with the shortest word. It times each `cs` and `sclk` transition against a free-running cycle counter.

// File: rtl/spi_cs_pkg.sv
// Shared types for the timed chip-select SPI master.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spi_state_t;
endpackage

// File: rtl/spi_cs_timer.sv
// Down-counting interval timer. A load sets the count; the count then falls by
// one per cycle and stops at zero. `expired` is high while the count is zero.
// Assumes: the user loads (interval - 1) to wait `interval` cycles.
module spi_cs_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load or decrement the interval count.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    // R2/R3: an expired timer stays expired until it is reloaded.
    a_r2_timer_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);
endmodule

// File: rtl/spi_cs_shifter.sv
// Transmit and receive shift registers. On load, the transmit word is
// left-aligned so that its top used bit drives mosi, and the receive register
// is cleared. shift_out advances mosi and shift_in captures miso.
// Assumes: shift_in and shift_out are never requested in the same cycle.
module spi_cs_shifter #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                shift_out,
    input  logic                shift_in,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_q;
    logic [LEN_W-1:0]    pad;

    // Shift distance that moves the top used bit to the MSB.
    always_comb pad = LEN_W'(MAX_BITS) - word_len;

    // Transmit register: load aligned word, shift left on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (load)      tx_q <= tx_word << pad;
        else if (shift_out) tx_q <= {tx_q[MAX_BITS-2:0], 1'b0};
    end

    // Receive register: clear at word start, shift in miso on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (load)     rx_q <= '0;
        else if (shift_in) rx_q <= {rx_q[MAX_BITS-2:0], miso};
    end

    assign mosi    = tx_q[MAX_BITS-1];
    assign rx_word = rx_q;

    // R6: capture never coincides with a transmit shift or a reload.
    a_r6_no_shift_clash: assert property (@(posedge clk) disable iff (!rst_n)
        shift_in |-> !(shift_out || load));
endmodule

// File: rtl/spi_cs_seq.sv
// Word sequencer. It runs the lead, shift and trail phases, produces sclk and
// the registered chip-select, and controls the timer and the shifter.
// Assumes: div_ratio is even in 2..MAX_DIV and word_len is in 4..MAX_BITS; the
// configuration is latched when start is accepted.
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int DIV_W = 9,
    parameter int TCS_W = 2,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] word_len,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [TCS_W-1:0] cs_lead,
    input  logic             cs_pol,
    input  logic             cs_manual,
    input  logic             cs_force,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_in,
    output logic             sh_out,
    output logic             sclk,
    output logic             cs,
    output logic             busy,
    output logic             done
);
    spi_state_t       state_q, state_d;
    logic [CNT_W-1:0] half_w, odd_w, lead_w;
    logic [CNT_W-1:0] half_q, lead_q;
    logic             mode_q, pol_q;
    logic [LEN_W-1:0] bits_q;
    logic             sclk_q, cs_q, done_q;
    logic             eff_manual, eff_pol, cs_d;

    // Half period and lead/trail length in system cycles from the live inputs.
    always_comb begin
        half_w = CNT_W'(div_ratio >> 1);
        odd_w  = CNT_W'({cs_lead, 1'b1});
        lead_w = odd_w * half_w;
    end

    // Next state plus timer and shifter strobes.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_in    = 1'b0;
        sh_out   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_LEAD;
                sh_load  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = (cs_manual ? half_w : lead_w) - CNT_W'(1);
            end
            ST_LEAD: if (tmr_expired) begin
                state_d  = ST_SHIFT;
                sh_in    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = half_q - CNT_W'(1);
            end
            ST_SHIFT: if (tmr_expired) begin
                if (sclk_q) begin
                    if (bits_q == LEN_W'(1)) begin
                        if (mode_q) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d  = ST_TRAIL;
                            tmr_load = 1'b1;
                            tmr_val  = lead_q - CNT_W'(1);
                        end
                    end else begin
                        sh_out   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = half_q - CNT_W'(1);
                    end
                end else begin
                    sh_in    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = half_q - CNT_W'(1);
                end
            end
            ST_TRAIL: if (tmr_expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Chip-select target: manual follows force; automatic is active while busy.
    always_comb begin
        eff_manual = (state_q == ST_IDLE) ? cs_manual : mode_q;
        eff_pol    = (state_q == ST_IDLE) ? cs_pol    : pol_q;
        if (eff_manual) cs_d = cs_force ? eff_pol : ~eff_pol;
        else            cs_d = (state_d != ST_IDLE) ? eff_pol : ~eff_pol;
    end

    // State register and end-of-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    // Latch the word configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            lead_q <= '0;
            mode_q <= 1'b0;
            pol_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            half_q <= half_w;
            lead_q <= lead_w;
            mode_q <= cs_manual;
            pol_q  <= cs_pol;
        end
    end

    // Serial clock level and the count of bits still to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            bits_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            bits_q <= word_len;
        end else if (sh_in) begin
            sclk_q <= 1'b1;
        end else if (state_q == ST_SHIFT && tmr_expired && sclk_q) begin
            sclk_q <= 1'b0;
            bits_q <= bits_q - LEN_W'(1);
        end
    end

    // Registered chip-select output; reset parks it at the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= ~cs_pol;
        else        cs_q <= cs_d;
    end

    assign sclk = sclk_q;
    assign cs   = cs_q;
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    // R4: the serial clock is low whenever no word is in flight.
    a_r4_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sclk_q);
    // R3: automatic chip-select holds its active level through a whole word.
    a_r3_cs_held_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !mode_q) |-> (cs_q == pol_q));
    // R10: the end-of-word pulse lasts one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R9: configuration of a word in flight is not disturbed.
    a_r9_cfg_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(pol_q) && $stable(half_q)));
    // R11: the shift phase always has a bit left to finish.
    a_r11_bits_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (bits_q != '0));
endmodule

// File: rtl/spi_cs_master.sv
// Single-word SPI master (mode 0, MSB first) with a hardware-timed or
// software-forced chip-select. This is the top level that connects the
// sequencer, the interval timer and the shift registers.
// Assumes: inputs are synchronous to clk; div_ratio even in 2..MAX_DIV.
module spi_cs_master #(
    parameter int MAX_BITS = 32,
    parameter int MAX_DIV  = 256,
    parameter int TCS_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [MAX_BITS-1:0]               tx_word,
    input  logic [$clog2(MAX_BITS+1)-1:0]     word_len,
    input  logic [$clog2(MAX_DIV+1)-1:0]      div_ratio,
    input  logic [TCS_W-1:0]                  cs_lead,
    input  logic                              cs_pol,
    input  logic                              cs_manual,
    input  logic                              cs_force,
    input  logic                              miso,
    output logic                              sclk,
    output logic                              mosi,
    output logic                              cs,
    output logic                              busy,
    output logic                              done,
    output logic [MAX_BITS-1:0]               rx_word
);
    localparam int LEN_W = $clog2(MAX_BITS + 1);
    localparam int DIV_W = $clog2(MAX_DIV + 1);
    localparam int CNT_W = $clog2(((2 ** (TCS_W + 1)) - 1) * (MAX_DIV / 2) + 1);

    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_in, sh_out;

    spi_cs_seq #(
        .LEN_W(LEN_W), .DIV_W(DIV_W), .TCS_W(TCS_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .word_len(word_len),
        .div_ratio(div_ratio), .cs_lead(cs_lead), .cs_pol(cs_pol),
        .cs_manual(cs_manual), .cs_force(cs_force), .tmr_expired(tmr_expired),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .sh_load(sh_load),
        .sh_in(sh_in), .sh_out(sh_out), .sclk(sclk), .cs(cs),
        .busy(busy), .done(done)
    );

    spi_cs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    spi_cs_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_word(tx_word),
        .word_len(word_len), .shift_out(sh_out), .shift_in(sh_in),
        .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );
endmodule

// File: tb/tb_spi_cs_master.sv
// Directed bench for spi_cs_master. Each scenario is one task that checks its
// own results against timings worked out from the requirements.
module tb_spi_cs_master;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] tx_word;
    logic [5:0]  word_len;
    logic [8:0]  div_ratio;
    logic [1:0]  cs_lead;
    logic        cs_pol, cs_manual, cs_force, miso;
    logic        sclk, mosi, cs, busy, done;
    logic [31:0] rx_word;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_cs_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .div_ratio(div_ratio), .cs_lead(cs_lead),
        .cs_pol(cs_pol), .cs_manual(cs_manual), .cs_force(cs_force),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs(cs), .busy(busy),
        .done(done), .rx_word(rx_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one word, acting as the peripheral, and checks timing and data.
    task automatic xfer(input int len, input logic [31:0] word, input logic [31:0] sword,
                        input int div, input int tcs, input bit pol, input bit man,
                        input bit frc, input bit mid_start, input string tag);
        int t_busy = -1, t_cs = -1, t_rise = -1, t_lfall = -1, t_off = -1, t_done = -1;
        int nrise = 0, nfall = 0, bad_per = 0, prev_rise = -1, cs_bad = 0;
        int hh, ll;
        logic [31:0] got = '0, mask, rx_at_done = '0;
        logic psclk = 1'b0;
        hh   = div / 2;
        ll   = man ? hh : (2 * tcs + 1) * hh;
        mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
        @(negedge clk);
        tx_word = word; word_len = 6'(len); div_ratio = 9'(div); cs_lead = 2'(tcs);
        cs_pol = pol; cs_manual = man; cs_force = frc;
        miso = sword[len-1]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            if (k > 0) @(negedge clk);
            if (busy && t_busy < 0) t_busy = cyc;
            if (!man && t_cs < 0 && cs == pol) t_cs = cyc;
            if (sclk && !psclk) begin
                nrise++;
                got = {got[30:0], mosi};
                if (t_rise < 0) t_rise = cyc;
                else if (cyc - prev_rise != div) bad_per++;
                prev_rise = cyc;
            end
            if (!sclk && psclk) begin
                nfall++;
                t_lfall = cyc;
                if (nfall < len) miso = sword[len-1-nfall];
                if (mid_start && nfall == 2) begin
                    tx_word = ~word; start = 1'b1;
                end
            end else begin
                start = 1'b0;
            end
            if (man && cs != (frc ? pol : ~pol)) cs_bad++;
            if (!man && t_cs >= 0 && t_off < 0 && cs != pol) t_off = cyc;
            if (!man && t_cs >= 0 && t_off < 0 && cs != pol && !done) cs_bad++;
            psclk = sclk;
            if (done) begin
                t_done = cyc;
                rx_at_done = rx_word;
                break;
            end
        end
        start = 1'b0;
        chk(t_done >= 0, {tag, " R10 done seen"}, t_done, 1);
        if (!man) begin
            chk(t_cs == t_busy, {tag, " R2 cs active with busy"}, t_cs, t_busy);
            chk(t_rise - t_cs == ll, {tag, " R2 lead cycles"}, t_rise - t_cs, ll);
            chk(t_off - t_lfall == ll, {tag, " R3 trail cycles"}, t_off - t_lfall, ll);
            chk(t_done == t_off, {tag, " R10 done with cs release"}, t_done, t_off);
        end else begin
            chk(t_rise - t_busy == hh, {tag, " R7 manual lead"}, t_rise - t_busy, hh);
            chk(t_done == t_lfall, {tag, " R10 done at last fall"}, t_done, t_lfall);
        end
        chk(cs_bad == 0, {tag, " R3/R7 cs level during word"}, cs_bad, 0);
        chk(nrise == len, {tag, " R4 rising edge count"}, nrise, len);
        chk(bad_per == 0, {tag, " R4 sclk period"}, bad_per, 0);
        chk((got & mask) == (word & mask), {tag, " R5 mosi bits"}, got & mask, word & mask);
        chk(rx_at_done == (sword & mask), {tag, " R6 rx_word"}, rx_at_done, sword & mask);
        @(negedge clk);
        chk(!busy && !sclk, {tag, " R9 idle after done"}, {busy, sclk}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_pol = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs == 1'b0, "R1 reset cs inactive high-pol", cs, 0);
        cs_pol = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs == 1'b1, "R1 reset cs inactive low-pol", cs, 1);
        chk(!sclk && !busy && !done, "R1 reset sclk/busy/done", {sclk, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs == 1'b1 && !busy, "R1 idle after reset", {cs, busy}, 2);
    endtask

    task automatic t_auto_basic();
        xfer(8, 32'h0000_00A5, 32'h0000_003C, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0, "auto8");
    endtask

    task automatic t_fast_long_lead();
        xfer(32, 32'hDEAD_BEEF, 32'h1234_5678, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0, "div2 R11 len32");
    endtask

    task automatic t_slow_short();
        xfer(4, 32'hFFFF_FFF9, 32'hFFFF_FFF6, 256, 1, 1'b0, 1'b0, 1'b0, 1'b0, "div256 R11 len4");
    endtask

    task automatic t_busy_start();
        xfer(12, 32'h0000_0B3C, 32'h0000_05A1, 6, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R9 start while busy");
    endtask

    task automatic t_polarity();
        @(negedge clk);
        cs_manual = 1'b0; cs_pol = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs == 1'b0, "R8 idle cs low when active-high", cs, 0);
        xfer(16, 32'h0000_C3A5, 32'h0000_7E81, 4, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 active-high");
        chk(cs == 1'b0, "R8 cs released low", cs, 0);
        @(negedge clk);
        cs_pol = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs == 1'b1, "R8 idle cs high when active-low", cs, 1);
    endtask

    task automatic t_manual();
        @(negedge clk);
        cs_manual = 1'b1; cs_pol = 1'b0; cs_force = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs == 1'b0, "R7 forced active while idle", cs, 0);
        xfer(8, 32'h0000_0081, 32'h0000_00C7, 4, 3, 1'b0, 1'b1, 1'b1, 1'b0, "manual w1");
        chk(cs == 1'b0, "R7 cs held after word", cs, 0);
        xfer(10, 32'h0000_02AA, 32'h0000_0155, 10, 0, 1'b0, 1'b1, 1'b1, 1'b0, "manual w2");
        @(negedge clk);
        cs_force = 1'b0;
        @(negedge clk);
        chk(cs == 1'b1, "R7 released by force bit", cs, 1);
        cs_manual = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; tx_word = '0; word_len = 6'd8; div_ratio = 9'd8;
        cs_lead = 2'd0; cs_pol = 1'b0; cs_manual = 1'b0; cs_force = 1'b0; miso = 1'b0;
        t_reset();
        t_auto_basic();
        t_fast_long_lead();
        t_slow_short();
        t_busy_start();
        t_polarity();
        t_manual();
        t_auto_basic();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule